// File: doc/BRIEF.md
# Scroll and Video Address Register

This block keeps the scroll position and the video memory address of a tile-based video processor. It holds a 15-bit working address `v` and a 15-bit staging address `t`, a 3-bit horizontal pixel offset and a write-phase toggle. The processor bus writes three ports: control, scroll and address. The scroll and address ports each take two bytes in a row, and the shared toggle decides which byte lands where. A status-read strobe puts the toggle back to the first phase.

The frame timing generator drives the block during rendering. It sends per-dot commands that step the coarse column, step the row, and copy the horizontal or vertical fields from `t` into `v`. A data-port access also moves `v`. While rendering, it performs a column step and a row step. Otherwise it adds a step of 1 or 32. After reset the block ignores the bus writes for a fixed settling period.

The address field layout is fixed because the fetch logic decodes it. Bits 4:0 hold the coarse column. Bits 9:5 hold the coarse row. Bit 10 selects the horizontal table and bit 11 selects the vertical table. Bits 14:12 hold the fine row. The four tables form a 2x2 arrangement, and `v` wraps across it.

Top module: `scroll_addr_reg`

## Requirements
- R1: After reset, `v_addr`, `t_addr`, `fine_x` and `wr_toggle` are all zero, and the data-port step is 1.
- R2: Writes to the control, scroll and address ports have no effect until WARMUP_CYCLES clock cycles have passed since reset. The default is 88974. Data accesses and status reads still act during this period.
- R3: A control write (`cpu_port`=0) sets t[11:10] to data[1:0]. It selects a data-port step of 32 when data[2]=1 and a step of 1 when data[2]=0. It leaves `v_addr` unchanged.
- R4: A scroll write (`cpu_port`=1) with the toggle at 0 sets t[4:0] to data[7:3] and `fine_x` to data[2:0], and sets the toggle. With the toggle at 1, it sets t[9:5] to data[7:3] and t[14:12] to data[2:0], and clears the toggle.
- R5: An address write (`cpu_port`=2) with the toggle at 0 sets t[13:8] to data[5:0], clears t[14] and sets the toggle. With the toggle at 1, it sets t[7:0] to data, loads `v_addr` with the resulting `t`, and clears the toggle.
- R6: A status read clears the toggle. The next scroll or address write is then taken as a first byte.
- R7: A coarse-column step adds 1 to v[4:0]. Going from 31 to 0 inverts v[10]. No other bit changes.
- R8: A row step adds 1 to the fine row. When the fine row passes 7, it becomes 0 and the coarse row advances. Coarse row 29 goes to 0 and inverts v[11]. Coarse row 31 goes to 0 and leaves v[11] as it was.
- R9: A horizontal copy moves t[4:0] and t[10] into `v_addr`. A vertical copy moves t[14:11] and t[9:5] into `v_addr`. The other bits of `v_addr` keep their values.
- R10: A data access with `render_on`=1 applies one column step and then one row step. With `render_on`=0 it adds the selected step to `v_addr`, wrapping modulo 2^15.
- R11: In one cycle, a second address write overrides every other change to `v_addr`. Otherwise the changes apply in this order: plain step, column step, row step, horizontal copy, vertical copy. A data access while rendering merges with a same-cycle step command into a single step.
- R12: A write to port code 3 changes neither `t_addr`, `fine_x` nor `wr_toggle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | Bus write strobe |
| cpu_port | input | 2 | Port code: 0 control, 1 scroll, 2 address, 3 unused |
| cpu_data | input | 8 | Bus write data |
| status_rd | input | 1 | Status read strobe, clears the toggle |
| data_acc | input | 1 | Data-port read or write strobe |
| render_on | input | 1 | Rendering enabled and on a pre-render or visible line |
| inc_coarse_x | input | 1 | Coarse-column step command |
| inc_y | input | 1 | Row step command |
| copy_x | input | 1 | Horizontal copy command |
| copy_y | input | 1 | Vertical copy command |
| v_addr | output | 15 | Working address |
| t_addr | output | 15 | Staging address |
| fine_x | output | 3 | Horizontal pixel offset |
| wr_toggle | output | 1 | Write-phase toggle |

## Verification
The case that needs the most care is a second address write arriving in the same cycle as a render-time column step or a data access. In that cycle both the bus side and the timing generator are trying to move `v`. The bench drives the final address byte and a column step on the same dot and expects `v` to equal the freshly packed `t`, with no increment applied. It also pairs a rendering data access with an explicit column step on one dot and expects exactly one column step and one row step.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int AW = 15;

  typedef enum logic [1:0] {
    PORT_CTRL   = 2'd0,
    PORT_SCROLL = 2'd1,
    PORT_ADDR   = 2'd2,
    PORT_NONE   = 2'd3
  } port_e;

  // coarse column step with horizontal table flip on wrap
  function automatic logic [AW-1:0] step_col(input logic [AW-1:0] a);
    logic [AW-1:0] r;
    r = a;
    if (a[4:0] == 5'd31) begin
      r[4:0] = 5'd0;
      r[10]  = ~a[10];
    end else begin
      r[4:0] = a[4:0] + 5'd1;
    end
    return r;
  endfunction

  // row step: fine row, then coarse row with wrap rules
  function automatic logic [AW-1:0] step_row(input logic [AW-1:0] a);
    logic [2:0] fy;
    logic [4:0] cy;
    logic       ny;
    fy = a[14:12];
    cy = a[9:5];
    ny = a[11];
    if (fy != 3'd7) begin
      fy = fy + 3'd1;
    end else begin
      fy = 3'd0;
      if (cy == 5'd29) begin
        cy = 5'd0;
        ny = ~ny;
      end else if (cy == 5'd31) begin
        cy = 5'd0;
      end else begin
        cy = cy + 5'd1;
      end
    end
    return {fy, ny, a[10], cy, a[4:0]};
  endfunction

  function automatic logic [AW-1:0] take_horiz(input logic [AW-1:0] v,
                                               input logic [AW-1:0] t);
    return {v[14:11], t[10], v[9:5], t[4:0]};
  endfunction

  function automatic logic [AW-1:0] take_vert(input logic [AW-1:0] v,
                                              input logic [AW-1:0] t);
    return {t[14:11], v[10], t[9:5], v[4:0]};
  endfunction
endpackage

// File: rtl/scr_warmup.sv
module scr_warmup #(
  parameter int WARMUP_CYCLES = 88974
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  localparam int CW = $clog2(WARMUP_CYCLES + 2);
  localparam logic [CW-1:0] LIMIT = CW'(WARMUP_CYCLES);

  logic [CW-1:0] cnt_q;

  assign ready = (cnt_q == LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!ready) cnt_q <= cnt_q + 1'b1;
  end

  // R2
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
endmodule

// File: rtl/scr_cpu_port.sv
module scr_cpu_port
  import scr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ready,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_port,
  input  logic [7:0]    cpu_data,
  input  logic          status_rd,
  output logic [AW-1:0] t_q,
  output logic [2:0]    fine_x_q,
  output logic          w_q,
  output logic          step32_q,
  output logic          load_v,
  output logic [AW-1:0] load_val
);
  logic          accept;
  logic [AW-1:0] t_n;
  logic [2:0]    fx_n;
  logic          w_n;
  logic          s32_n;

  assign accept   = cpu_wr && ready;
  assign load_val = t_n;

  always_comb begin
    t_n    = t_q;
    fx_n   = fine_x_q;
    w_n    = w_q;
    s32_n  = step32_q;
    load_v = 1'b0;
    if (accept) begin
      case (port_e'(cpu_port))
        PORT_CTRL: begin
          t_n[11:10] = cpu_data[1:0];
          s32_n      = cpu_data[2];
        end
        PORT_SCROLL: begin
          if (!w_q) begin
            t_n[4:0] = cpu_data[7:3];
            fx_n     = cpu_data[2:0];
            w_n      = 1'b1;
          end else begin
            t_n[14:12] = cpu_data[2:0];
            t_n[9:5]   = cpu_data[7:3];
            w_n        = 1'b0;
          end
        end
        PORT_ADDR: begin
          if (!w_q) begin
            t_n[13:8] = cpu_data[5:0];
            t_n[14]   = 1'b0;
            w_n       = 1'b1;
          end else begin
            t_n[7:0] = cpu_data;
            w_n      = 1'b0;
            load_v   = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (status_rd) w_n = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t_q      <= '0;
      fine_x_q <= '0;
      w_q      <= 1'b0;
      step32_q <= 1'b0;
    end else begin
      t_q      <= t_n;
      fine_x_q <= fx_n;
      w_q      <= w_n;
      step32_q <= s32_n;
    end
  end

  // R6
  status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_rd |=> !w_q);
  // R2
  warmup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> ($stable(t_q) && $stable(fine_x_q)));
  // R12
  unused_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_port == 2'd3 && !status_rd) |=> ($stable(t_q) && $stable(w_q)));
endmodule

// File: rtl/scr_v_reg.sv
module scr_v_reg
  import scr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] t_q,
  input  logic          load_v,
  input  logic [AW-1:0] load_val,
  input  logic          step32,
  input  logic          data_acc,
  input  logic          render_on,
  input  logic          inc_coarse_x,
  input  logic          inc_y,
  input  logic          copy_x,
  input  logic          copy_y,
  output logic [AW-1:0] v_q
);
  logic          plain_step;
  logic          do_col;
  logic          do_row;
  logic [AW-1:0] step_amt;
  logic [AW-1:0] s0, s1, s2, s3, s4;

  assign plain_step = data_acc && !render_on;
  assign do_col     = inc_coarse_x || (data_acc && render_on);
  assign do_row     = inc_y        || (data_acc && render_on);
  assign step_amt   = step32 ? AW'(32) : AW'(1);

  assign s0 = plain_step ? (v_q + step_amt) : v_q;
  assign s1 = do_col ? step_col(s0) : s0;
  assign s2 = do_row ? step_row(s1) : s1;
  assign s3 = copy_x ? take_horiz(s2, t_q) : s2;
  assign s4 = copy_y ? take_vert(s3, t_q) : s3;

  always_ff @(posedge clk) begin
    if (!rst_n)      v_q <= '0;
    else if (load_v) v_q <= load_val;
    else             v_q <= s4;
  end

  // R9
  copy_horiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_x && !load_v) |=> (v_q[4:0] == $past(t_q[4:0]) && v_q[10] == $past(t_q[10])));
  // R9
  copy_vert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (copy_y && !load_v) |=> (v_q[14:11] == $past(t_q[14:11]) && v_q[9:5] == $past(t_q[9:5])));
  // R7
  col_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_coarse_x && !inc_y && !data_acc && !copy_x && !copy_y && !load_v)
      |=> (v_q[14:11] == $past(v_q[14:11]) && v_q[9:5] == $past(v_q[9:5])));
endmodule

// File: rtl/scroll_addr_reg.sv
module scroll_addr_reg
  import scr_pkg::*;
#(
  parameter int WARMUP_CYCLES = 88974
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_wr,
  input  logic [1:0]  cpu_port,
  input  logic [7:0]  cpu_data,
  input  logic        status_rd,
  input  logic        data_acc,
  input  logic        render_on,
  input  logic        inc_coarse_x,
  input  logic        inc_y,
  input  logic        copy_x,
  input  logic        copy_y,
  output logic [14:0] v_addr,
  output logic [14:0] t_addr,
  output logic [2:0]  fine_x,
  output logic        wr_toggle
);
  logic          ready;
  logic          step32;
  logic          load_v;
  logic [AW-1:0] load_val;
  logic          v_cmd_any;

  scr_warmup #(.WARMUP_CYCLES(WARMUP_CYCLES)) u_warm (
    .clk(clk), .rst_n(rst_n), .ready(ready)
  );

  scr_cpu_port u_port (
    .clk(clk), .rst_n(rst_n), .ready(ready),
    .cpu_wr(cpu_wr), .cpu_port(cpu_port), .cpu_data(cpu_data),
    .status_rd(status_rd),
    .t_q(t_addr), .fine_x_q(fine_x), .w_q(wr_toggle), .step32_q(step32),
    .load_v(load_v), .load_val(load_val)
  );

  scr_v_reg u_v (
    .clk(clk), .rst_n(rst_n), .t_q(t_addr),
    .load_v(load_v), .load_val(load_val), .step32(step32),
    .data_acc(data_acc), .render_on(render_on),
    .inc_coarse_x(inc_coarse_x), .inc_y(inc_y),
    .copy_x(copy_x), .copy_y(copy_y),
    .v_q(v_addr)
  );

  assign v_cmd_any = data_acc || inc_coarse_x || inc_y || copy_x || copy_y;

  // R5 / R11
  addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_v |=> (v_addr == t_addr && !wr_toggle));
  // R3
  ctrl_keep_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_port == 2'd0 && !v_cmd_any) |=> $stable(v_addr));
endmodule

// File: tb/scroll_addr_reg_tb.sv
module scroll_addr_reg_tb;
  localparam int WU = 40;
  localparam logic [1:0] P_CTRL = 2'd0, P_SCR = 2'd1, P_ADR = 2'd2, P_NONE = 2'd3;

  logic clk = 0;
  logic rst_n = 0;
  logic cpu_wr = 0;
  logic [1:0] cpu_port = 0;
  logic [7:0] cpu_data = 0;
  logic status_rd = 0, data_acc = 0, render_on = 0;
  logic inc_coarse_x = 0, inc_y = 0, copy_x = 0, copy_y = 0;
  logic [14:0] v_addr, t_addr;
  logic [2:0]  fine_x;
  logic        wr_toggle;

  int n_run = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  scroll_addr_reg #(.WARMUP_CYCLES(WU)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_port(cpu_port),
    .cpu_data(cpu_data), .status_rd(status_rd), .data_acc(data_acc),
    .render_on(render_on), .inc_coarse_x(inc_coarse_x), .inc_y(inc_y),
    .copy_x(copy_x), .copy_y(copy_y), .v_addr(v_addr), .t_addr(t_addr),
    .fine_x(fine_x), .wr_toggle(wr_toggle)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] p, input logic [7:0] d);
    cpu_wr = 1; cpu_port = p; cpu_data = d;
    @(negedge clk);
    cpu_wr = 0;
  endtask

  task automatic st_rd();
    status_rd = 1;
    @(negedge clk);
    status_rd = 0;
  endtask

  task automatic cmd(input bit da, input bit ro, input bit cx, input bit iy,
                     input bit hx, input bit vy);
    data_acc = da; render_on = ro; inc_coarse_x = cx; inc_y = iy;
    copy_x = hx; copy_y = vy;
    @(negedge clk);
    data_acc = 0; render_on = 0; inc_coarse_x = 0; inc_y = 0; copy_x = 0; copy_y = 0;
  endtask

  // build an arbitrary v through the staging register and both copies
  task automatic set_v(input int fy, input int cy, input int nt, input int cx,
                       input bit s32);
    st_rd();
    bus_wr(P_CTRL, 8'((s32 ? 4 : 0) | nt));
    bus_wr(P_SCR, 8'(cx * 8));
    bus_wr(P_SCR, 8'(cy * 8 + fy));
    cmd(0, 0, 0, 0, 1, 1);
  endtask

  function automatic int pack(input int fy, input int cy, input int nt, input int cx);
    return fy * 4096 + nt * 1024 + cy * 32 + cx;
  endfunction

  function automatic int exp_col(input int v);
    int hz;
    hz = ((v >> 10) & 1) * 32 + (v & 31);
    hz = (hz + 1) % 64;
    return (v & ~(1024 | 31)) | ((hz / 32) * 1024) | (hz % 32);
  endfunction

  function automatic int exp_row(input int v);
    int r, ny;
    r  = ((v >> 5) & 31) * 8 + ((v >> 12) & 7) + 1;
    ny = (v >> 11) & 1;
    if (r == 240) begin r = 0; ny = 1 - ny; end
    else if (r == 256) r = 0;
    return pack(r % 8, r / 8, ny * 2 + ((v >> 10) & 1), v & 31);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check(v_addr == 0 && t_addr == 0 && fine_x == 0 && !wr_toggle, "R1", v_addr, 0);

    // R2 writes ignored during warmup; data access still steps
    bus_wr(P_CTRL, 8'h07);
    bus_wr(P_SCR, 8'hFF);
    bus_wr(P_ADR, 8'h3F);
    check(t_addr == 0 && fine_x == 0 && !wr_toggle, "R2", t_addr, 0);
    cmd(1, 0, 0, 0, 0, 0);
    check(v_addr == 1, "R2 step during warmup (R1 step is 1)", v_addr, 1);
    repeat (WU + 5) @(negedge clk);

    // R12 unused port
    bus_wr(P_NONE, 8'hFF);
    check(t_addr == 0 && fine_x == 0 && !wr_toggle, "R12", t_addr, 0);

    // R3 control sweep
    for (int d = 0; d < 4; d++) begin
      e = v_addr;
      bus_wr(P_CTRL, 8'(d));
      check(t_addr == d * 1024 && v_addr == e, "R3", t_addr, d * 1024);
    end

    // R4 scroll sweep
    for (int d = 0; d < 256; d++) begin
      st_rd();
      bus_wr(P_CTRL, 8'h00);
      e = t_addr;
      bus_wr(P_SCR, 8'(d));
      check(t_addr == ((e & ~31) | (d / 8)) && fine_x == d % 8 && wr_toggle,
            "R4 first", t_addr, (e & ~31) | (d / 8));
      e = t_addr;
      bus_wr(P_SCR, 8'(255 - d));
      check(t_addr == ((e & 15'h0C1F) | (((255 - d) % 8) * 4096) | (((255 - d) / 8) * 32))
            && !wr_toggle && fine_x == d % 8, "R4 second", t_addr,
            (e & 15'h0C1F) | (((255 - d) % 8) * 4096) | (((255 - d) / 8) * 32));
    end

    // R5 address sweep
    for (int d = 0; d < 256; d++) begin
      st_rd();
      e = t_addr;
      bus_wr(P_ADR, 8'(d));
      check(t_addr == ((e & 255) | ((d % 64) * 256)) && wr_toggle, "R5 first",
            t_addr, (e & 255) | ((d % 64) * 256));
      bus_wr(P_ADR, 8'(d ^ 8'hA5));
      e = (d % 64) * 256 + (d ^ 8'hA5);
      check(t_addr == e && v_addr == e && !wr_toggle, "R5 second", v_addr, e);
    end

    // R6 status read resets the phase
    st_rd();
    bus_wr(P_SCR, 8'h18);
    check(wr_toggle == 1, "R6 set", wr_toggle, 1);
    st_rd();
    check(wr_toggle == 0, "R6 clear", wr_toggle, 0);
    bus_wr(P_SCR, 8'h28);
    check(t_addr[4:0] == 5 && wr_toggle, "R6 next is first", t_addr[4:0], 5);

    // R7 column step sweep
    for (int nt = 0; nt < 4; nt++)
      for (int cx = 0; cx < 32; cx++) begin
        set_v(5, 17, nt, cx, 0);
        e = exp_col(pack(5, 17, nt, cx));
        cmd(0, 1, 1, 0, 0, 0);
        check(v_addr == e, "R7", v_addr, e);
      end

    // R8 row step sweep
    for (int ny = 0; ny < 2; ny++)
      for (int cy = 0; cy < 32; cy++)
        for (int fy = 0; fy < 8; fy++) begin
          set_v(fy, cy, ny * 2 + 1, 9, 0);
          e = exp_row(pack(fy, cy, ny * 2 + 1, 9));
          cmd(0, 1, 0, 1, 0, 0);
          check(v_addr == e, "R8", v_addr, e);
        end

    // R9 partial copies
    set_v(7, 31, 3, 31, 0);
    st_rd();
    bus_wr(P_CTRL, 8'h00);
    bus_wr(P_SCR, 8'h00);
    bus_wr(P_SCR, 8'h00);
    cmd(0, 0, 0, 0, 1, 0);
    check(v_addr == pack(7, 31, 2, 0), "R9 horiz", v_addr, pack(7, 31, 2, 0));
    cmd(0, 0, 0, 0, 0, 1);
    check(v_addr == 0, "R9 vert", v_addr, 0);

    // R10 data access modes
    set_v(7, 31, 3, 31, 0);
    cmd(1, 0, 0, 0, 0, 0);
    check(v_addr == 0, "R10 wrap", v_addr, 0);
    set_v(2, 3, 1, 4, 1);
    cmd(1, 0, 0, 0, 0, 0);
    e = pack(2, 3, 1, 4) + 32;
    check(v_addr == e, "R10 step32", v_addr, e);
    set_v(7, 29, 0, 31, 0);
    cmd(1, 1, 0, 0, 0, 0);
    e = exp_row(exp_col(pack(7, 29, 0, 31)));
    check(v_addr == e, "R10 rendering", v_addr, e);

    // R11 same-cycle interactions
    set_v(1, 2, 0, 3, 0);
    cmd(1, 1, 1, 0, 0, 0);
    e = exp_row(exp_col(pack(1, 2, 0, 3)));
    check(v_addr == e, "R11 merged step", v_addr, e);
    st_rd();
    bus_wr(P_ADR, 8'h12);
    cpu_wr = 1; cpu_port = P_ADR; cpu_data = 8'h34;
    inc_coarse_x = 1; render_on = 1; data_acc = 1;
    @(negedge clk);
    cpu_wr = 0; inc_coarse_x = 0; render_on = 0; data_acc = 0;
    check(v_addr == 15'h1234, "R11 address wins", v_addr, 15'h1234);
    set_v(3, 5, 0, 31, 0);
    st_rd();
    bus_wr(P_CTRL, 8'h00);
    bus_wr(P_SCR, 8'h50);
    cmd(0, 1, 1, 0, 1, 0);
    e = pack(3, 5, 0, 10);
    check(v_addr == e, "R11 copy after step", v_addr, e);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule